// File: doc/BRIEF.md
# Prefix Remap and Storage Key Updater

This block sits directly behind address translation in a processor's memory path. It takes a real address and an access length and returns the absolute address that memory should see. Each CPU owns a private 8 KiB low area. A real address inside the first 8 KiB is moved up to the CPU's prefix area. An address inside the prefix area is moved down to page zero. In both cases the length is trimmed so that the access stays inside the 8 KiB window. Other addresses pass through unchanged.

The block also keeps one 8-bit storage key per 4 KiB page in an internal register file. When an access is granted read permission, it sets the page's reference bit. When it is granted write permission, it sets the page's change bit. This only happens if the absolute address lies within installed memory. An address beyond the memory-plus-device limit raises an addressing fault and yields no mapping. A maintenance port reads any key and can clear it. Every result is registered: the answer for an input accepted at one clock edge appears after that edge, together with a report of the key write made at the same edge.

Top module: `pfx_key_unit`

## Requirements
- R1: A real address below 8192 maps to real address plus prefix.
- R2: A real address of at least 8192 that lies in the range prefix to prefix+8192 (exclusive) maps to real address minus prefix. When prefix is below 8192, the rule of R1 takes precedence.
- R3: For an address relocated by R1 or R2, the output length is the smaller of the requested length and 8192 minus the address's offset inside its window.
- R4: Any other address passes through unchanged, with its length unchanged.
- R5: If the absolute address (computed without truncation) exceeds the device limit, out_fault is 1, out_aaddr and out_len are 0, and no key changes.
- R6: An accepted, non-faulting access whose absolute address is at most the memory limit updates the key of page absolute>>12. Read permission sets key bit 2 (reference) and write permission sets key bit 1 (change). key_we pulses with out_valid and carries the page index and the resulting key byte. With neither permission, or above the memory limit, there is no key write.
- R7: mnt_key shows the key of page mnt_idx combinationally. mnt_clr zeroes that key at the clock edge. If an update hits the same page at the same edge, the key becomes only the newly set bits.
- R8: out_valid is 1 exactly in the cycle after a cycle with in_valid = 1. With in_valid low, key_we stays low.
- R9: After reset, all keys read 0, and out_valid and key_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_raddr | input | ADDR_W | Real address |
| in_len | input | LEN_W | Requested access length in bytes |
| in_prefix | input | ADDR_W | Per-CPU prefix value |
| in_mem_limit | input | ADDR_W | Highest address that receives key updates |
| in_dev_limit | input | ADDR_W | Highest address that does not fault |
| in_perm_rd | input | 1 | Read permission granted |
| in_perm_wr | input | 1 | Write permission granted |
| mnt_idx | input | ADDR_W-12 | Maintenance page index |
| mnt_clr | input | 1 | Clear key at mnt_idx |
| mnt_key | output | 8 | Key of page mnt_idx |
| out_valid | output | 1 | Result valid |
| out_aaddr | output | ADDR_W | Absolute address |
| out_len | output | LEN_W | Clamped length |
| out_fault | output | 1 | Addressing fault |
| key_we | output | 1 | A key was written at the last edge |
| key_idx | output | ADDR_W-12 | Page index of that write |
| key_wdata | output | 8 | Key value written |

## Verification
The bench targets the window edges:
- The last byte of each window must map. A design with an off-by-one bound would treat the byte at prefix+8192 as relocated, or the byte at prefix+8191 as passing through.
- A prefix below 8192 overlaps the low window. A design that checks the prefix window first would relocate low addresses downward.
- A sum that wraps past the address width must still fault. A design that truncates before comparing would hand back a small in-range address.

The bench also covers the key-side boundaries:
- An address exactly at the memory limit must update its key. A strict compare would skip it.
- A clear and an update that hit the same page at the same edge must leave only the new bits. A wrong ordering would either lose the clear or lose the update.

// File: rtl/pfx_key_pkg.sv
package pfx_key_pkg;

    localparam int KEY_W   = 8;
    localparam int REF_BIT = 2;
    localparam int CHG_BIT = 1;

    typedef enum logic [1:0] {
        MAP_LOW  = 2'd0,
        MAP_PFX  = 2'd1,
        MAP_PASS = 2'd2
    } map_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } perm_t;

    function automatic logic [KEY_W-1:0] key_set_bits(input perm_t p);
        logic [KEY_W-1:0] b;
        b = '0;
        b[REF_BIT] = p.rd;
        b[CHG_BIT] = p.wr;
        return b;
    endfunction

endpackage

// File: rtl/pfx_remap.sv
module pfx_remap
    import pfx_key_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int LEN_W     = 14,
    parameter int WIN_SHIFT = 13
) (
    input  logic [ADDR_W-1:0] raddr,
    input  logic [ADDR_W-1:0] prefix,
    input  logic [ADDR_W-1:0] dev_limit,
    input  logic [LEN_W-1:0]  len_in,
    output logic [ADDR_W-1:0] abs_addr,
    output logic [LEN_W-1:0]  len_out,
    output logic              fault
);
    localparam int XW = ADDR_W + 1;
    localparam int CW = (LEN_W > WIN_SHIFT + 1) ? LEN_W : WIN_SHIFT + 1;
    localparam logic [XW-1:0] WIN_X = XW'(1) << WIN_SHIFT;
    localparam logic [CW-1:0] WIN_C = CW'(1) << WIN_SHIFT;

    logic [XW-1:0] raddr_x, prefix_x, pfx_end, diff_x, abs_x;
    logic          in_low, in_pfx;
    logic [CW-1:0] off_c, remain_c, len_c, clamp_c;
    map_kind_e     kind;

    always_comb begin
        raddr_x  = {1'b0, raddr};
        prefix_x = {1'b0, prefix};
        pfx_end  = prefix_x + WIN_X;
        diff_x   = raddr_x - prefix_x;
        in_low   = raddr_x < WIN_X;
        in_pfx   = !in_low && (raddr_x >= prefix_x) && (raddr_x < pfx_end);
        kind     = in_low ? MAP_LOW : (in_pfx ? MAP_PFX : MAP_PASS);
        len_c    = CW'(len_in);
        off_c    = '0;
        abs_x    = raddr_x;
        unique case (kind)
            MAP_LOW: begin
                abs_x = raddr_x + prefix_x;
                off_c = CW'(raddr_x[WIN_SHIFT-1:0]);
            end
            MAP_PFX: begin
                abs_x = diff_x;
                off_c = CW'(diff_x[WIN_SHIFT-1:0]);
            end
            default: abs_x = raddr_x;
        endcase
        remain_c = WIN_C - off_c;
        clamp_c  = ((kind != MAP_PASS) && (remain_c < len_c)) ? remain_c : len_c;
        fault    = abs_x > {1'b0, dev_limit};
        abs_addr = fault ? '0 : abs_x[ADDR_W-1:0];
        len_out  = fault ? '0 : clamp_c[LEN_W-1:0];
    end

    // In-window accesses never run past the window end
    always_comb begin
        if (!fault && kind != MAP_PASS) begin
            assert_window_end_R3: assert ((CW+1)'(off_c) + (CW+1)'(clamp_c) <= (CW+1)'(WIN_C))
                else $error("R3 clamp crosses window end");
        end
    end

endmodule

// File: rtl/pfx_keyfile.sv
module pfx_keyfile
    import pfx_key_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int PAGES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [KEY_W-1:0] upd_set,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_data,
    output logic [KEY_W-1:0] upd_val
);
    logic [KEY_W-1:0] keys [PAGES];
    logic             clr_hit;

    assign clr_hit = clr_en && (clr_idx == upd_idx);
    assign upd_val = (clr_hit ? '0 : keys[upd_idx]) | upd_set;
    assign rd_data = keys[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAGES; i++) keys[i] <= '0;
        end else begin
            if (clr_en) keys[clr_idx] <= '0;
            if (upd_en) keys[upd_idx] <= upd_val;
        end
    end

    // A clear with no colliding update leaves the page reading zero
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(upd_en && clr_hit) && rd_idx == clr_idx) ##1 $stable(rd_idx) |-> rd_data == '0)
        else $error("R7 clear not applied");

endmodule

// File: rtl/pfx_key_unit.sv
module pfx_key_unit
    import pfx_key_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int LEN_W      = 14,
    parameter int WIN_SHIFT  = 13,
    parameter int PAGE_SHIFT = 12,
    localparam int IDX_W     = ADDR_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_raddr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [ADDR_W-1:0] in_prefix,
    input  logic [ADDR_W-1:0] in_mem_limit,
    input  logic [ADDR_W-1:0] in_dev_limit,
    input  logic              in_perm_rd,
    input  logic              in_perm_wr,
    input  logic [IDX_W-1:0]  mnt_idx,
    input  logic              mnt_clr,
    output logic [KEY_W-1:0]  mnt_key,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_aaddr,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_fault,
    output logic              key_we,
    output logic [IDX_W-1:0]  key_idx,
    output logic [KEY_W-1:0]  key_wdata
);
    localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(1) << WIN_SHIFT;

    logic [ADDR_W-1:0] abs_addr;
    logic [LEN_W-1:0]  len_clamped;
    logic              fault;
    perm_t             perm;
    logic              upd_en;
    logic [IDX_W-1:0]  upd_idx;
    logic [KEY_W-1:0]  upd_val;

    pfx_remap #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .WIN_SHIFT(WIN_SHIFT)
    ) remap_i (
        .raddr(in_raddr), .prefix(in_prefix), .dev_limit(in_dev_limit),
        .len_in(in_len), .abs_addr(abs_addr), .len_out(len_clamped), .fault(fault)
    );

    assign perm    = '{rd: in_perm_rd, wr: in_perm_wr};
    assign upd_en  = in_valid && !fault && (abs_addr <= in_mem_limit) && (perm.rd || perm.wr);
    assign upd_idx = abs_addr[ADDR_W-1:PAGE_SHIFT];

    pfx_keyfile #(.IDX_W(IDX_W)) keys_i (
        .clk(clk), .rst(rst),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_set(key_set_bits(perm)),
        .clr_en(mnt_clr), .clr_idx(mnt_idx), .rd_idx(mnt_idx),
        .rd_data(mnt_key), .upd_val(upd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_aaddr <= '0;
            out_len   <= '0;
            out_fault <= 1'b0;
            key_we    <= 1'b0;
            key_idx   <= '0;
            key_wdata <= '0;
        end else begin
            out_valid <= in_valid;
            key_we    <= upd_en;
            if (in_valid) begin
                out_aaddr <= abs_addr;
                out_len   <= len_clamped;
                out_fault <= fault;
            end
            if (upd_en) begin
                key_idx   <= upd_idx;
                key_wdata <= upd_val;
            end
        end
    end

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("R8 missing out_valid");
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !key_we) else $error("R8 spurious output");
    assert_fault_clean_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_fault |-> out_aaddr == '0 && out_len == '0 && !key_we)
        else $error("R5 fault output not clean");
    assert_key_bits_R6: assert property (@(posedge clk) disable iff (rst)
        key_we |-> out_valid && (key_wdata[REF_BIT] || key_wdata[CHG_BIT]))
        else $error("R6 key write without a set bit");
    assert_low_reloc_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_raddr < WIN_A |=>
        out_fault || out_aaddr == $past(in_raddr) + $past(in_prefix))
        else $error("R1 low relocation wrong");
    assert_low_len_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_raddr < WIN_A && in_len != '0 |=>
        out_fault || (out_len != '0 && out_len <= $past(in_len)))
        else $error("R3 low length wrong");

endmodule

// File: tb/pfx_key_unit_tb_top.sv
module pfx_key_unit_tb_top;
    localparam int ADDR_W = 20;
    localparam int LEN_W  = 14;
    localparam int IDX_W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [ADDR_W-1:0] in_raddr = '0, in_prefix = '0, in_mem_limit = '0, in_dev_limit = '0;
    logic [LEN_W-1:0]  in_len = '0;
    logic in_perm_rd = 1'b0, in_perm_wr = 1'b0;
    logic [IDX_W-1:0] mnt_idx = '0;
    logic mnt_clr = 1'b0;
    logic [7:0] mnt_key;
    logic out_valid, out_fault, key_we;
    logic [ADDR_W-1:0] out_aaddr;
    logic [LEN_W-1:0] out_len;
    logic [IDX_W-1:0] key_idx;
    logic [7:0] key_wdata;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int model [256];

    always #5 clk = ~clk;

    pfx_key_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_raddr(in_raddr), .in_len(in_len),
        .in_prefix(in_prefix), .in_mem_limit(in_mem_limit), .in_dev_limit(in_dev_limit),
        .in_perm_rd(in_perm_rd), .in_perm_wr(in_perm_wr), .mnt_idx(mnt_idx),
        .mnt_clr(mnt_clr), .mnt_key(mnt_key), .out_valid(out_valid), .out_aaddr(out_aaddr),
        .out_len(out_len), .out_fault(out_fault), .key_we(key_we), .key_idx(key_idx),
        .key_wdata(key_wdata)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // One request per call: drive at negedge, compare after the next posedge
    task automatic step(bit v, longint a, longint l, bit rd, bit wr, bit clr, int midx);
        longint p, ab, el;
        bit flt, we;
        int idx, wd;
        string areq, lreq;
        p = longint'(in_prefix);
        if (a < 8192) begin
            ab = a + p; el = (l < 8192 - a) ? l : 8192 - a; areq = "R1"; lreq = "R3";
        end else if (a >= p && a < p + 8192) begin
            ab = a - p; el = (l < 8192 - ab) ? l : 8192 - ab; areq = "R2"; lreq = "R3";
        end else begin
            ab = a; el = l; areq = "R4"; lreq = "R4";
        end
        flt = ab > longint'(in_dev_limit);
        if (flt) begin ab = 0; el = 0; areq = "R5"; lreq = "R5"; end
        we = v && !flt && ab <= longint'(in_mem_limit) && (rd || wr);
        idx = int'(ab >> 12) & 255;
        wd = ((clr && midx == idx) ? 0 : model[idx]) | (rd ? 4 : 0) | (wr ? 2 : 0);

        in_valid = v; in_raddr = ADDR_W'(a); in_len = LEN_W'(l);
        in_perm_rd = rd; in_perm_wr = wr; mnt_clr = clr; mnt_idx = IDX_W'(midx);
        @(posedge clk);
        if (clr) model[midx] = 0;
        if (we) model[idx] = wd;
        @(negedge clk);
        chk(out_valid == v, "R8", "out_valid", out_valid, v);
        if (v) begin
            chk(out_fault == flt, "R5", "out_fault", out_fault, flt);
            chk(longint'(out_aaddr) == ab, areq, "out_aaddr", out_aaddr, ab);
            chk(longint'(out_len) == el, lreq, "out_len", out_len, el);
        end
        chk(key_we == we, "R6", "key_we", key_we, we);
        if (we) begin
            chk(int'(key_idx) == idx, "R6", "key_idx", key_idx, idx);
            chk(int'(key_wdata) == wd, (clr && midx == idx) ? "R7" : "R6", "key_wdata", key_wdata, wd);
        end
        mnt_clr = 1'b0;
        chk(int'(mnt_key) == model[midx], "R7", "mnt_key", mnt_key, model[midx]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 0;
        in_prefix = 20'h24000; in_mem_limit = 20'hC0000; in_dev_limit = 20'hF0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0 && key_we == 0, "R9", "outputs in reset", {out_valid, key_we}, 0);
        rst = 1'b0;
        for (int i = 0; i < 256; i += 37) begin
            mnt_idx = IDX_W'(i); #1;
            chk(mnt_key == 0, "R9", "key after reset", mnt_key, 0);
        end
        @(negedge clk);
        chk(out_valid == 0, "R9", "out_valid after reset", out_valid, 0);

        step(1, 'h100, 64, 1, 0, 0, 'h24);          // R1 low reloc, reference bit
        step(1, 'h1F00, 'h400, 0, 1, 0, 'h24);      // R3 clamp, change bit
        step(1, 'h25000, 'h2000, 1, 1, 0, 1);       // R2 window down
        step(1, 'h24000 + 8191, 100, 1, 0, 0, 1);   // R2 last byte
        step(1, 'h24000 + 8192, 100, 1, 0, 0, 'h26); // R4 just past window
        step(1, 'h50000, 'h3000, 0, 1, 0, 'h50);    // R4 pass
        step(1, 'hC0800, 8, 1, 1, 0, 'hC0);         // above mem limit: no key
        step(1, 'hC0000, 8, 1, 0, 0, 'hC0);         // R6 equal to mem limit
        step(1, 'hF0001, 8, 1, 1, 0, 'hF0);         // R5 fault
        step(1, 'hF0000, 8, 1, 1, 0, 'hF0);         // R5 limit itself ok
        step(1, 'h300, 16, 0, 0, 0, 'h24);          // R6 no perms
        step(0, 'h300, 16, 1, 1, 0, 'h24);          // R8 idle
        step(1, 'h1000, 16, 0, 1, 1, 'h25);         // R7 clear + update same page
        step(0, 0, 0, 0, 0, 1, 'h24);               // R7 plain clear
        in_prefix = 20'hFFF00;
        step(1, 'h200, 16, 1, 0, 0, 0);             // R5 wrapped sum faults
        in_prefix = 20'h01000;
        step(1, 'h1800, 'h2000, 1, 0, 0, 2);        // R1 precedence over R2
        step(1, 'h2800, 'h2000, 0, 1, 0, 1);        // R2 with small prefix

        for (int n = 0; n < 600; n++) begin
            if (n % 50 == 0) in_prefix = ADDR_W'($urandom_range(0, 'hFFFFF));
            if (n % 3 == 0)
                step($urandom_range(0, 5) != 0, longint'($urandom_range(0, 'h3FFF)),
                     $urandom_range(0, 'h3FFF), $urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 7) == 0, $urandom_range(0, 255));
            else
                step($urandom_range(0, 5) != 0,
                     longint'(in_prefix) + longint'($urandom_range(0, 'h2100)) - 'h80,
                     $urandom_range(0, 'h3FFF), $urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 7) == 0, $urandom_range(0, 255));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule